// File: doc/BRIEF.md
# Sleep Mode and Wake Controller

This block decides when a small processor core is put to sleep and which of its clock domains are switched off while it sleeps. A configuration register holds a sleep-enable flag and a three-bit mode code. The core raises a one-cycle strobe when it executes its sleep instruction. Sleep begins only if the enable flag is set in that same cycle. The mode code then chooses one of four depths of sleep, and each depth gates a different set of clock enables.

An enabled interrupt wakes the core. So does a level-type wake source that has stayed high long enough. On wake the block counts a start-up delay that depends on the sleep depth. It then holds the CPU for four more cycles. Only after that does it grant the interrupt to the core, together with a pulse telling the core to continue after the sleep instruction. A reset request that arrives at any point before that grant ends the sequence at once. In that case the block sends the core to its reset vector instead. A two-bit phase output exposes the sequence so that each step can be timed from outside.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: Sleep is entered only when `sleepStrobe` is high while the stored enable flag is 1. When the flag is 0, the strobe leaves `phaseStatus` at awake and every clock enable high.
- R2: The stored mode code selects the sleep depth: 000 Idle, 001 ADC noise reduction, 010 Standby, 011 Power-down. Codes 100 to 111 behave exactly like Idle, both in clock gating and in start-up delay.
- R3: While sleeping in Idle, `clkEnCpu` and `clkEnNvm` are 0, and `clkEnIo`, `clkEnAdc` and `oscRun` are 1.
- R4: While sleeping, ADC noise reduction drives `clkEnIo` to 0 and keeps `clkEnAdc` at 1. Standby drives all four domain enables to 0 and keeps `oscRun` at 1. Power-down drives all four domain enables and `oscRun` to 0.
- R5: An `irqReq` that is high in a sleeping cycle starts a wake-up, so the next cycle is no longer sleeping. While awake, `irqReq` has no effect: no grant follows.
- R6: After the wake cycle, the phase stays at start-up for D cycles, where D is the delay of the sleep mode (defaults: 0 for Idle, 2 for ADC noise reduction, 6 for Standby, 16 for Power-down). During start-up the clock gating of the mode is kept, but `oscRun` is 1.
- R7: After start-up the phase is halt for exactly 4 cycles, with `clkEnCpu` 0 and all other enables 1. The next cycle is awake, and `irqGrant` and `resumeNext` are both high for that single cycle.
- R8: A `sysResetReq` during sleep, start-up or halt makes the next cycle awake with `resetVector` high for one cycle. Neither `irqGrant` nor `resumeNext` is raised for that wake.
- R9: When `irqLevel` stays high for `LEVEL_MIN` consecutive sleeping cycles (default 3), a wake-up starts after the last of those cycles. A shorter high pulse leaves the block sleeping.
- R10: `phaseStatus` encodes the phase as 00 awake, 01 sleeping, 10 start-up and 11 halt. It reads 00, with all enables high, right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| cfgWe | input | 1 | Write strobe for the configuration register |
| cfgSleepEn | input | 1 | Sleep-enable value to store |
| cfgMode | input | 3 | Sleep mode code to store |
| sleepStrobe | input | 1 | One-cycle pulse: the core executed its sleep instruction |
| irqReq | input | 1 | Enabled interrupt request (edge-type wake source) |
| irqLevel | input | 1 | Level-type wake source that needs a minimum hold time |
| sysResetReq | input | 1 | System reset request seen by the block |
| clkEnCpu | output | 1 | CPU clock enable |
| clkEnNvm | output | 1 | Non-volatile memory clock enable |
| clkEnIo | output | 1 | Enable for the timer, comparator, watchdog and interrupt-logic clocks |
| clkEnAdc | output | 1 | Converter clock enable |
| oscRun | output | 1 | Main oscillator keep-running request |
| irqGrant | output | 1 | One-cycle grant of the wake interrupt to the core |
| resumeNext | output | 1 | One-cycle pulse: continue after the sleep instruction |
| resetVector | output | 1 | One-cycle pulse: restart the core from the reset vector |
| phaseStatus | output | 2 | Current phase (see R10) |

## Verification
Every output of this block is a registered phase, or is decoded from that phase and the latched mode, so each stimulus first shows up one cycle after the edge that samples it. Sleep entry is visible one cycle after the strobe. A reset redirect is visible one cycle after the request. A level wake is visible one cycle after the `LEVEL_MIN`-th high sample. The grant arrives D + 5 cycles after the cycle in which the interrupt was sampled. The driver computes those cycle numbers from the requirements and queues one expected snapshot of all outputs for each such cycle. The monitor compares the ports with those snapshots on the falling edge, and it flags a snapshot whose cycle has passed without being checked.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [1:0] {
    PH_AWAKE = 2'b00,
    PH_SLEEP = 2'b01,
    PH_START = 2'b10,
    PH_HALT  = 2'b11
  } phase_t;

  typedef enum logic [1:0] {
    SM_IDLE,
    SM_ADCNR,
    SM_STBY,
    SM_PDOWN
  } smode_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic enterSleep;
    logic loadStart;
    logic loadHalt;
    logic countDown;
  } ctrl_strobe_t;

  localparam int HALT_CYCLES = 4;

  function automatic smode_t decodeMode(input logic [2:0] code);
    case (code)
      3'b001:  return SM_ADCNR;
      3'b010:  return SM_STBY;
      3'b011:  return SM_PDOWN;
      default: return SM_IDLE;
    endcase
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sleep_dp.sv
module sleep_dp
  import sleep_pkg::*;
#(
  parameter int DLY_IDLE  = 0,
  parameter int DLY_ADC   = 2,
  parameter int DLY_STBY  = 6,
  parameter int DLY_PDOWN = 16,
  parameter int LEVEL_MIN = 3,
  parameter int MODE_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgSleepEn,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              irqLevel,
  input  phase_t            phase,
  input  ctrl_strobe_t      strb,
  output logic              sleepEnQ,
  output logic              dlyZero,
  output logic              cntZero,
  output logic              levelOk,
  output logic              clkEnCpu,
  output logic              clkEnNvm,
  output logic              clkEnIo,
  output logic              clkEnAdc,
  output logic              oscRun
);

  localparam int PEAK   = maxOf(maxOf(DLY_IDLE, DLY_ADC), maxOf(DLY_STBY, DLY_PDOWN));
  localparam int CNT_W  = $clog2(PEAK + HALT_CYCLES + 1);
  localparam int LVL_W  = $clog2(LEVEL_MIN + 1);
  localparam logic [CNT_W-1:0] HALT_LAST = CNT_W'(HALT_CYCLES - 1);
  localparam logic [LVL_W-1:0] LVL_LAST  = LVL_W'(LEVEL_MIN - 1);

  logic [MODE_W-1:0] regMode;
  smode_t            sleepMode;
  logic [CNT_W-1:0]  phaseCnt;
  logic [CNT_W-1:0]  dlyCycles;
  logic [LVL_W-1:0]  levelCnt;

  // configuration register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepEnQ <= 1'b0;
      regMode  <= '0;
    end else if (cfgWe) begin
      sleepEnQ <= cfgSleepEn;
      regMode  <= cfgMode;
    end
  end

  // mode latched at sleep entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sleepMode <= SM_IDLE;
    else if (strb.enterSleep) sleepMode <= decodeMode(regMode[2:0]);
  end

  always_comb begin
    case (sleepMode)
      SM_ADCNR: dlyCycles = CNT_W'(DLY_ADC);
      SM_STBY:  dlyCycles = CNT_W'(DLY_STBY);
      SM_PDOWN: dlyCycles = CNT_W'(DLY_PDOWN);
      default:  dlyCycles = CNT_W'(DLY_IDLE);
    endcase
  end

  assign dlyZero = (dlyCycles == '0);
  assign cntZero = (phaseCnt == '0);

  // shared start-up / halt down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               phaseCnt <= '0;
    else if (strb.loadStart) phaseCnt <= dlyCycles - 1'b1;
    else if (strb.loadHalt)  phaseCnt <= HALT_LAST;
    else if (strb.countDown) phaseCnt <= phaseCnt - 1'b1;
  end

  // level wake qualifier: consecutive high samples while sleeping
  assign levelOk = (phase == PH_SLEEP) && irqLevel && (levelCnt == LVL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 levelCnt <= '0;
    else if (phase != PH_SLEEP || !irqLevel)   levelCnt <= '0;
    else if (!levelOk)                         levelCnt <= levelCnt + 1'b1;
  end

  // clock-enable decode
  always_comb begin
    clkEnCpu = 1'b1;
    clkEnNvm = 1'b1;
    clkEnIo  = 1'b1;
    clkEnAdc = 1'b1;
    oscRun   = 1'b1;
    case (phase)
      PH_HALT: clkEnCpu = 1'b0;
      PH_SLEEP, PH_START: begin
        clkEnCpu = 1'b0;
        clkEnNvm = 1'b0;
        clkEnIo  = (sleepMode == SM_IDLE);
        clkEnAdc = (sleepMode == SM_IDLE) || (sleepMode == SM_ADCNR);
        oscRun   = (sleepMode != SM_PDOWN) || (phase == PH_START);
      end
      default: ;
    endcase
  end

  assert_cpu_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_AWAKE) |-> !clkEnCpu);

  assert_short_level_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SLEEP && !irqLevel) |=> (levelCnt == '0));

  assert_pdown_osc_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.enterSleep && regMode == 3'b011) |=> !oscRun);

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sleepStrobe,
  input  logic         irqReq,
  input  logic         sysResetReq,
  input  logic         sleepEnQ,
  input  logic         dlyZero,
  input  logic         cntZero,
  input  logic         levelOk,
  output phase_t       phase,
  output ctrl_strobe_t strb,
  output logic         irqGrant,
  output logic         resumeNext,
  output logic         resetVector
);

  phase_t nextPhase;
  logic   grantNext;
  logic   redirNext;

  always_comb begin
    nextPhase = phase;
    strb      = '0;
    grantNext = 1'b0;
    redirNext = 1'b0;
    if (phase == PH_AWAKE) begin
      if (sleepStrobe && sleepEnQ) begin
        strb.enterSleep = 1'b1;
        nextPhase       = PH_SLEEP;
      end
    end else if (sysResetReq) begin
      nextPhase = PH_AWAKE;
      redirNext = 1'b1;
    end else begin
      case (phase)
        PH_SLEEP: if (irqReq || levelOk) begin
          if (dlyZero) begin
            strb.loadHalt = 1'b1;
            nextPhase     = PH_HALT;
          end else begin
            strb.loadStart = 1'b1;
            nextPhase      = PH_START;
          end
        end
        PH_START: if (cntZero) begin
          strb.loadHalt = 1'b1;
          nextPhase     = PH_HALT;
        end else begin
          strb.countDown = 1'b1;
        end
        PH_HALT: if (cntZero) begin
          nextPhase = PH_AWAKE;
          grantNext = 1'b1;
        end else begin
          strb.countDown = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_AWAKE;
      irqGrant    <= 1'b0;
      resumeNext  <= 1'b0;
      resetVector <= 1'b0;
    end else begin
      phase       <= nextPhase;
      irqGrant    <= grantNext;
      resumeNext  <= grantNext;
      resetVector <= redirNext;
    end
  end

  assert_no_entry_without_enable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_AWAKE && sleepStrobe && !sleepEnQ) |=> (phase == PH_AWAKE));

  assert_awake_irq_no_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_AWAKE) |=> !irqGrant);

  assert_grant_follows_halt_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HALT && !sysResetReq && !cntZero) |=> (phase == PH_HALT));

  assert_reset_redirect_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_AWAKE && sysResetReq) |=> (phase == PH_AWAKE && resetVector && !irqGrant && !resumeNext));

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_pkg::*;
#(
  parameter int DLY_IDLE  = 0,
  parameter int DLY_ADC   = 2,
  parameter int DLY_STBY  = 6,
  parameter int DLY_PDOWN = 16,
  parameter int LEVEL_MIN = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic       cfgSleepEn,
  input  logic [2:0] cfgMode,
  input  logic       sleepStrobe,
  input  logic       irqReq,
  input  logic       irqLevel,
  input  logic       sysResetReq,
  output logic       clkEnCpu,
  output logic       clkEnNvm,
  output logic       clkEnIo,
  output logic       clkEnAdc,
  output logic       oscRun,
  output logic       irqGrant,
  output logic       resumeNext,
  output logic       resetVector,
  output logic [1:0] phaseStatus
);

  phase_t       phase;
  ctrl_strobe_t strb;
  logic         sleepEnQ, dlyZero, cntZero, levelOk;

  sleep_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .sleepStrobe(sleepStrobe), .irqReq(irqReq), .sysResetReq(sysResetReq),
    .sleepEnQ(sleepEnQ), .dlyZero(dlyZero), .cntZero(cntZero), .levelOk(levelOk),
    .phase(phase), .strb(strb),
    .irqGrant(irqGrant), .resumeNext(resumeNext), .resetVector(resetVector)
  );

  sleep_dp #(
    .DLY_IDLE(DLY_IDLE), .DLY_ADC(DLY_ADC), .DLY_STBY(DLY_STBY),
    .DLY_PDOWN(DLY_PDOWN), .LEVEL_MIN(LEVEL_MIN), .MODE_W(3)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSleepEn(cfgSleepEn), .cfgMode(cfgMode),
    .irqLevel(irqLevel), .phase(phase), .strb(strb),
    .sleepEnQ(sleepEnQ), .dlyZero(dlyZero), .cntZero(cntZero), .levelOk(levelOk),
    .clkEnCpu(clkEnCpu), .clkEnNvm(clkEnNvm), .clkEnIo(clkEnIo),
    .clkEnAdc(clkEnAdc), .oscRun(oscRun)
  );

  assign phaseStatus = phase;

endmodule

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;

  localparam int LVL = 3;
  localparam int D0 = 0, D1 = 2, D2 = 6, D3 = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0, cfgSleepEn = 1'b0;
  logic [2:0] cfgMode = '0;
  logic sleepStrobe = 1'b0, irqReq = 1'b0, irqLevel = 1'b0, sysResetReq = 1'b0;
  logic clkEnCpu, clkEnNvm, clkEnIo, clkEnAdc, oscRun;
  logic irqGrant, resumeNext, resetVector;
  logic [1:0] phaseStatus;

  always #4 clk = ~clk;

  sleep_wake_ctrl #(
    .DLY_IDLE(D0), .DLY_ADC(D1), .DLY_STBY(D2), .DLY_PDOWN(D3), .LEVEL_MIN(LVL)
  ) i_sleep_wake_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSleepEn(cfgSleepEn), .cfgMode(cfgMode),
    .sleepStrobe(sleepStrobe), .irqReq(irqReq), .irqLevel(irqLevel), .sysResetReq(sysResetReq),
    .clkEnCpu(clkEnCpu), .clkEnNvm(clkEnNvm), .clkEnIo(clkEnIo), .clkEnAdc(clkEnAdc),
    .oscRun(oscRun), .irqGrant(irqGrant), .resumeNext(resumeNext),
    .resetVector(resetVector), .phaseStatus(phaseStatus)
  );

  typedef struct {
    int         cyc;
    logic [1:0] st;
    logic [4:0] ck;
    logic       g;
    logic       rn;
    logic       rv;
    string      req;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int delayOf(int m);
    case (m)
      1: return D1;
      2: return D2;
      3: return D3;
      default: return D0;
    endcase
  endfunction

  // expected {cpu,nvm,io,adc,osc}
  function automatic logic [4:0] gateOf(logic [1:0] st, int m);
    logic [4:0] g;
    case (st)
      2'b00: g = 5'b11111;
      2'b11: g = 5'b01111;
      default: begin
        case (m)
          1: g = 5'b00011;
          2: g = 5'b00001;
          3: g = 5'b00000;
          default: g = 5'b00111;
        endcase
        if (st == 2'b10) g[0] = 1'b1;
      end
    endcase
    return g;
  endfunction

  task automatic expectAt(int c, logic [1:0] st, int m, logic g, logic rn, logic rv, string req);
    exp_t e;
    e.cyc = c; e.st = st; e.ck = gateOf(st, m); e.g = g; e.rn = rn; e.rv = rv; e.req = req;
    sbq.push_back(e);
  endtask

  // monitor: compare on falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      exp_t e;
      logic [9:0] act, exv;
      e = sbq.pop_front();
      total++;
      act = {phaseStatus, clkEnCpu, clkEnNvm, clkEnIo, clkEnAdc, oscRun, irqGrant, resumeNext, resetVector};
      exv = {e.st, e.ck, e.g, e.rn, e.rv};
      if (e.cyc < cyc) begin
        bad++;
        $display("FAIL %s cycle %0d missed: actual=none expected=%b", e.req, e.cyc, exv);
      end else if (act !== exv) begin
        bad++;
        $display("FAIL %s cycle %0d: actual=%b expected=%b", e.req, e.cyc, act, exv);
      end
    end
  end

  task automatic waitTo(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic writeCfg(logic en, logic [2:0] code);
    @(negedge clk);
    cfgWe = 1'b1; cfgSleepEn = en; cfgMode = code;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // R1 R2: enter sleep, check two sleeping cycles; returns at a sleeping cycle
  task automatic enterSleep(logic [2:0] code, string req);
    int m;
    m = (code < 3'd4) ? int'(code) : 0;
    writeCfg(1'b1, code);
    sleepStrobe = 1'b1;
    expectAt(cyc + 1, 2'b01, m, 0, 0, 0, req);
    expectAt(cyc + 2, 2'b01, m, 0, 0, 0, req);
    @(negedge clk);
    sleepStrobe = 1'b0;
    @(negedge clk);
  endtask

  // full wake sequence, R5/R9 wake source then R6 R7 timing
  task automatic wakeFull(logic [2:0] code, bit useLevel);
    int m, d, w;
    m = (code < 3'd4) ? int'(code) : 0;
    d = delayOf(m);
    if (useLevel) begin
      w = cyc + LVL - 1;
      for (int k = cyc + 1; k <= w; k++) expectAt(k, 2'b01, m, 0, 0, 0, "R9");
    end else w = cyc;
    for (int k = 1; k <= d; k++) expectAt(w + k, 2'b10, m, 0, 0, 0, "R6");
    for (int k = 1; k <= 4; k++) expectAt(w + d + k, 2'b11, m, 0, 0, 0, "R7");
    expectAt(w + d + 5, 2'b00, m, 1, 1, 0, "R7");
    expectAt(w + d + 6, 2'b00, m, 0, 0, 0, "R7");
    if (useLevel) begin
      irqLevel = 1'b1;
      waitTo(w + 1);
      irqLevel = 1'b0;
    end else begin
      irqReq = 1'b1;
      @(negedge clk);
      irqReq = 1'b0;
    end
    waitTo(w + d + 7);
  endtask

  // R8: reset request off cycles after an irq wake (off < 0: while sleeping)
  task automatic resetDuring(logic [2:0] code, int off);
    int m, d, w;
    m = int'(code);
    d = delayOf(m);
    enterSleep(code, "R8");
    if (off >= 0) begin
      w = cyc;
      for (int k = 1; k <= off; k++)
        expectAt(w + k, (k <= d) ? 2'b10 : 2'b11, m, 0, 0, 0, "R8");
      irqReq = 1'b1;
      @(negedge clk);
      irqReq = 1'b0;
      waitTo(w + off);
    end
    sysResetReq = 1'b1;
    expectAt(cyc + 1, 2'b00, m, 0, 0, 1, "R8");
    expectAt(cyc + 2, 2'b00, m, 0, 0, 0, "R8");
    @(negedge clk);
    sysResetReq = 1'b0;
    waitTo(cyc + 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: reset state
    expectAt(cyc + 1, 2'b00, 0, 0, 0, 0, "R10");
    waitTo(cyc + 2);

    // R1: strobe with enable cleared is ignored
    writeCfg(1'b0, 3'b011);
    sleepStrobe = 1'b1;
    expectAt(cyc + 1, 2'b00, 0, 0, 0, 0, "R1");
    expectAt(cyc + 2, 2'b00, 0, 0, 0, 0, "R1");
    @(negedge clk);
    sleepStrobe = 1'b0;
    waitTo(cyc + 3);

    // R5: interrupt while awake gives no grant
    irqReq = 1'b1;
    expectAt(cyc + 1, 2'b00, 0, 0, 0, 0, "R5");
    expectAt(cyc + 2, 2'b00, 0, 0, 0, 0, "R5");
    @(negedge clk);
    irqReq = 1'b0;
    waitTo(cyc + 3);

    // R3 Idle, R4 other modes, R6 R7 timing with irq wake
    enterSleep(3'b000, "R3");
    wakeFull(3'b000, 1'b0);
    enterSleep(3'b001, "R4");
    wakeFull(3'b001, 1'b0);
    enterSleep(3'b010, "R4");
    wakeFull(3'b010, 1'b0);
    enterSleep(3'b011, "R4");
    wakeFull(3'b011, 1'b0);

    // R2: reserved codes behave as Idle
    enterSleep(3'b101, "R2");
    wakeFull(3'b101, 1'b0);
    enterSleep(3'b111, "R2");
    wakeFull(3'b111, 1'b0);

    // R9: short level pulse ignored, then full-length level wakes
    enterSleep(3'b010, "R9");
    irqLevel = 1'b1;
    for (int k = 1; k <= LVL + 2; k++) expectAt(cyc + k, 2'b01, 2, 0, 0, 0, "R9");
    waitTo(cyc + LVL - 1);
    irqLevel = 1'b0;
    waitTo(cyc + 3);
    wakeFull(3'b010, 1'b1);

    // R8: reset while sleeping, during start-up, during halt
    resetDuring(3'b001, -1);
    resetDuring(3'b011, 3);
    resetDuring(3'b000, 2);

    waitTo(cyc + 2);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL R7 leftover expectations: actual=%0d expected=0", sbq.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 5000 && !finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=cycle %0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule